// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a behavioural, synthesizable model of a single-clock burst memory. It stores 36-bit words split into four 9-bit byte lanes, and its depth is set by a parameter. On each rising clock edge it samples every control and data input. It then classifies the cycle as one of four kinds: deselect, burst start at the external address, burst continue, or burst suspend.

A two-bit counter steps through four consecutive word addresses. The counter wraps inside the aligned group of four and leaves the upper address bits fixed.

There are two address strobes, and they follow different rules:
- The processor-side strobe is masked by a gating chip select. A cycle it starts is always a read.
- The controller-side strobe can start either a read or a write at the external address.

The tri-state data bus is split into separate ports. Write data comes in on its own input. Read data goes out on its own output together with an output-valid flag. An asynchronous output-enable input gates both outputs.

Top module: `burst_sram`

## Requirements
- R1: During and after reset the block is deselected: `rvalid_o` is 0 and `rdata_o` is all zeros until a new burst starts.
- R2: With the processor strobe low, the gating select low, the active-high select high and the active-low select low, a read burst starts at `addr_i`.
- R3: While the gating select `cs_gate_n_i` is high, the processor strobe has no effect. With the controller strobe high, the cycle then continues or suspends the current burst.
- R4: A cycle is a deselect when either strobe is accepted while any chip select is inactive. A deselect writes nothing, and the output stays at zero with `rvalid_o` low.
- R5: A burst started by the processor strobe is a read whatever the values of the byte write enables, and memory is left unchanged.
- R6: A burst started by the controller strobe is a write if any bit of `bwe_n_i` is 0, and a read if all four bits are 1.
- R7: With both strobes inactive and `adv_n_i` low, the access moves to the next burst address. The next address is (start low two bits + count) mod 4, with the upper address bits unchanged.
- R8: With both strobes inactive and `adv_n_i` high, the current burst address is accessed again.
- R9: `bwe_n_i[k]` is active low and controls bits 9k to 9k+8 (lane 0 is bits 0-8, lane 3 is bits 27-35). Only the lanes whose enable is 0 are written.
- R10: `rvalid_o` is 1 only in a read cycle while `oe_n_i` is low. Otherwise `rdata_o` is all zeros. Output enable acts with no clock.
- R11: Continue and suspend cycles that arrive while the block is deselected write nothing and produce no read data.
- R12: Read data for an address sampled at a clock edge appears on `rdata_o` in the clock cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all sampling on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | LANES*LANE_W | Write data |
| adsp_n_i | input | 1 | Processor-side address strobe, active low |
| adsc_n_i | input | 1 | Controller-side address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| cs_gate_n_i | input | 1 | Gating chip select, active low; masks the processor strobe |
| cs_hi_i | input | 1 | Chip select, active high |
| cs_lo_n_i | input | 1 | Chip select, active low |
| bwe_n_i | input | LANES | Byte write enables, active low, one per lane |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driven |
| rvalid_o | output | 1 | Output drivers active |

## Verification
The assertions are checked on every cycle and cover these rules:
- Output data is zero whenever the valid flag is low.
- Output enable high forces the bus off.
- Reset, deselect cycles and write cycles leave the bus undriven on the following cycle.
- A started processor read drives the bus on the following cycle whenever output enable is low.
- A continue or suspend that follows a deselect never drives the bus.

The bench scenarios cover what a single-cycle property cannot: memory contents and lane masking, the wrap order of the burst counter, suspend repeating an address, a masked processor strobe falling through to a suspend, and a blocked write that leaves the stored data intact.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int unsigned BS_LANE_W  = 9;
    localparam int unsigned BS_LANES   = 4;
    localparam int unsigned BS_ADDR_W  = 6;
    localparam int unsigned BS_BURST_W = 2;

    // Kind of clock cycle after decode
    typedef enum logic [1:0] {
        CY_DESEL = 2'd0,
        CY_START = 2'd1,
        CY_CONT  = 2'd2,
        CY_SUSP  = 2'd3
    } cyc_e;

    // Array operation for the cycle
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        cyc_e kind;
        op_e  op;
    } cmd_t;

    // Linear wrap inside an aligned group of four words
    function automatic logic [BS_BURST_W-1:0] burst_low(
        input logic [BS_BURST_W-1:0] start,
        input logic [BS_BURST_W-1:0] count
    );
        return start + count;
    endfunction

endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W = BS_ADDR_W,
    parameter int unsigned LANES  = BS_LANES
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              adsp_n_i,
    input  logic              adsc_n_i,
    input  logic              adv_n_i,
    input  logic              cs_gate_n_i,
    input  logic              cs_hi_i,
    input  logic              cs_lo_n_i,
    input  logic [LANES-1:0]  bwe_n_i,
    output cmd_t              cmd_o,
    output logic [ADDR_W-1:0] acc_o
);

    localparam int unsigned HI_W = ADDR_W - BS_BURST_W;

    logic                  live_q, live_d;
    logic [ADDR_W-1:0]     base_q, base_d;
    logic [BS_BURST_W-1:0] cnt_q, cnt_d;
    cmd_t                  cmd_q, cmd_d;
    logic [ADDR_W-1:0]     acc_q, acc_d;

    logic sel_all;
    logic proc_go;
    logic any_wr;

    assign sel_all = !cs_gate_n_i && cs_hi_i && !cs_lo_n_i;
    assign proc_go = !cs_gate_n_i && !adsp_n_i;
    assign any_wr  = !(&bwe_n_i);

    always_comb begin
        cmd_d  = '{kind: CY_DESEL, op: OP_NONE};
        live_d = live_q;
        base_d = base_q;
        cnt_d  = cnt_q;
        if (proc_go) begin
            // processor strobe: always a read
            if (sel_all) begin
                cmd_d  = '{kind: CY_START, op: OP_READ};
                live_d = 1'b1;
                base_d = addr_i;
                cnt_d  = '0;
            end else begin
                live_d = 1'b0;
            end
        end else if (!adsc_n_i) begin
            if (sel_all) begin
                cmd_d.kind = CY_START;
                cmd_d.op   = any_wr ? OP_WRITE : OP_READ;
                live_d     = 1'b1;
                base_d     = addr_i;
                cnt_d      = '0;
            end else begin
                live_d = 1'b0;
            end
        end else if (live_q) begin
            cmd_d.kind = adv_n_i ? CY_SUSP : CY_CONT;
            cmd_d.op   = any_wr ? OP_WRITE : OP_READ;
            if (!adv_n_i) begin
                cnt_d = cnt_q + 1'b1;
            end
        end
        acc_d = {base_d[ADDR_W-1 -: HI_W],
                 burst_low(base_d[BS_BURST_W-1:0], cnt_d)};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            live_q <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
            cmd_q  <= '{kind: CY_DESEL, op: OP_NONE};
            acc_q  <= '0;
        end else begin
            live_q <= live_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
            cmd_q  <= cmd_d;
            acc_q  <= acc_d;
        end
    end

    assign cmd_o = cmd_q;
    assign acc_o = acc_q;

endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W = BS_ADDR_W,
    parameter int unsigned LANES  = BS_LANES,
    parameter int unsigned LANE_W = BS_LANE_W
) (
    input  logic                    clk_i,
    input  logic                    we_i,
    input  logic [LANES-1:0]        be_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk_i) begin
            if (we_i && be_i[k]) begin
                cells[addr_i] <= wdata_i[k*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[k*LANE_W +: LANE_W] = cells[addr_i];
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W = BS_ADDR_W,
    parameter int unsigned LANES  = BS_LANES,
    parameter int unsigned LANE_W = BS_LANE_W,
    localparam int unsigned WORD_W = LANES * LANE_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              adsp_n_i,
    input  logic              adsc_n_i,
    input  logic              adv_n_i,
    input  logic              cs_gate_n_i,
    input  logic              cs_hi_i,
    input  logic              cs_lo_n_i,
    input  logic [LANES-1:0]  bwe_n_i,
    input  logic              oe_n_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              rvalid_o
);

    cmd_t              cmd;
    logic [ADDR_W-1:0] acc;
    logic [WORD_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic [WORD_W-1:0] cell_rd;

    bsram_ctrl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_ctrl (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .addr_i      (addr_i),
        .adsp_n_i    (adsp_n_i),
        .adsc_n_i    (adsc_n_i),
        .adv_n_i     (adv_n_i),
        .cs_gate_n_i (cs_gate_n_i),
        .cs_hi_i     (cs_hi_i),
        .cs_lo_n_i   (cs_lo_n_i),
        .bwe_n_i     (bwe_n_i),
        .cmd_o       (cmd),
        .acc_o       (acc)
    );

    // write data and lane enables are sampled on the same edge as the command
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wdata_q <= '0;
            be_q    <= '0;
        end else begin
            wdata_q <= wdata_i;
            be_q    <= ~bwe_n_i;
        end
    end

    bsram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk_i   (clk_i),
        .we_i    (cmd.op == OP_WRITE),
        .be_i    (be_q),
        .addr_i  (acc),
        .wdata_i (wdata_q),
        .rdata_o (cell_rd)
    );

    // asynchronous output enable on the drivers
    assign rvalid_o = (cmd.op == OP_READ) && !oe_n_i;
    assign rdata_o  = rvalid_o ? cell_rd : '0;

endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned WORD_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              cs_gate_n,
    input logic              cs_hi,
    input logic              cs_lo_n,
    input logic [LANES-1:0]  bwe_n,
    input logic              oe_n,
    input logic [WORD_W-1:0] rdata,
    input logic              rvalid
);

    logic sel_all, proc_go, desel_now, ctl_write, proc_start, no_strobe;

    assign sel_all    = !cs_gate_n && cs_hi && !cs_lo_n;
    assign proc_go    = !cs_gate_n && !adsp_n;
    assign proc_start = proc_go && sel_all;
    assign desel_now  = (proc_go && !sel_all) || (!proc_go && !adsc_n && !sel_all);
    assign ctl_write  = !proc_go && !adsc_n && sel_all && !(&bwe_n);
    assign no_strobe  = !proc_go && adsc_n;

    // R10: bus is zero when not driven
    p_zero_when_off_r10: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> (rdata == '0));

    // R10: output enable high blocks the drivers
    p_oe_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !rvalid);

    // R1: reset leaves the bus off
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !rvalid);

    // R4: deselect cycle produces no output
    p_desel_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        desel_now |=> !rvalid);

    // R6: controller write start produces no output
    p_write_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        ctl_write |=> !rvalid);

    // R2: processor start reads whenever output enable is low
    p_proc_read_r2: assert property (@(posedge clk) disable iff (rst)
        proc_start |=> (oe_n || rvalid));

    // R11: continue or suspend right after a deselect stays quiet
    p_dead_burst_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(desel_now) && no_strobe) |=> !rvalid);

endmodule

bind burst_sram bsram_chk #(
    .LANES  (LANES),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk_i),
    .rst       (rst_i),
    .adsp_n    (adsp_n_i),
    .adsc_n    (adsc_n_i),
    .cs_gate_n (cs_gate_n_i),
    .cs_hi     (cs_hi_i),
    .cs_lo_n   (cs_lo_n_i),
    .bwe_n     (bwe_n_i),
    .oe_n      (oe_n_i),
    .rdata     (rdata_o),
    .rvalid    (rvalid_o)
);

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;

    localparam int AW = 6;
    localparam int WW = 36;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic [WW-1:0] wd;
    logic          adsp_n, adsc_n, adv_n, cg_n, chi, clo_n, oe_n;
    logic [3:0]    bwe_n;
    logic [WW-1:0] rdata;
    logic          rvalid;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [WW-1:0] mem_m [64];
    bit            live_m = 0;
    int            base_m = 0;
    int            cnt_m  = 0;
    bit            exp_rd = 0;
    int            exp_a  = 0;

    always #4 clk = ~clk;

    burst_sram u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .addr_i      (addr),
        .wdata_i     (wd),
        .adsp_n_i    (adsp_n),
        .adsc_n_i    (adsc_n),
        .adv_n_i     (adv_n),
        .cs_gate_n_i (cg_n),
        .cs_hi_i     (chi),
        .cs_lo_n_i   (clo_n),
        .bwe_n_i     (bwe_n),
        .oe_n_i      (oe_n),
        .rdata_o     (rdata),
        .rvalid_o    (rvalid)
    );

    task automatic access(input int a);
        if (bwe_n != 4'hF) begin
            for (int k = 0; k < 4; k++)
                if (!bwe_n[k]) mem_m[a][k*9 +: 9] = wd[k*9 +: 9];
            exp_rd = 0;
        end else begin
            exp_rd = 1;
        end
        exp_a = a;
    endtask

    task automatic model_step();
        bit sel;
        sel = !cg_n && chi && !clo_n;
        exp_rd = 0;
        if (rst) begin
            live_m = 0;
            cnt_m  = 0;
        end else if (!cg_n && !adsp_n) begin
            if (sel) begin
                live_m = 1; base_m = addr; cnt_m = 0;
                exp_rd = 1; exp_a = addr;
            end else live_m = 0;
        end else if (!adsc_n) begin
            if (sel) begin
                live_m = 1; base_m = addr; cnt_m = 0;
                access(addr);
            end else live_m = 0;
        end else if (live_m) begin
            if (!adv_n) cnt_m = (cnt_m + 1) % 4;
            access((base_m & ~3) | ((base_m + cnt_m) % 4));
        end
    endtask

    task automatic go(input string tag);
        logic          ev;
        logic [WW-1:0] ed;
        @(posedge clk);
        model_step();
        #2;
        ev = exp_rd && !oe_n;
        ed = ev ? mem_m[exp_a] : '0;
        checks++;
        if (rvalid !== ev || rdata !== ed) begin
            errors++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tag, rvalid, rdata, ev, ed);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; addr = '0; wd = '0; adsp_n = 1; adsc_n = 1; adv_n = 1;
        cg_n = 0; chi = 1; clo_n = 0; oe_n = 0; bwe_n = 4'hF;
        go("R1"); go("R1");
        rst = 0;
        go("R1");                       // deselected after reset, no strobe
        // R6/R7: controller write burst at 12, wraps back to 12
        adsc_n = 0; addr = 6'd12; bwe_n = 4'h0; wd = 36'h0A0A0A0A0;
        go("R6");
        adsc_n = 1; adv_n = 0;
        wd = 36'h1A1A1A1A1; go("R7");
        wd = 36'h2A2A2A2A2; go("R7");
        wd = 36'h3A3A3A3A3; go("R7");
        wd = 36'h4A4A4A4A4; go("R7");   // wraps to 12
        // R2/R12: processor read burst from 14: 14,15,12,13
        bwe_n = 4'hF; adsp_n = 0; addr = 6'd14; adv_n = 1;
        go("R2 R12");
        adsp_n = 1; adv_n = 0;
        go("R7"); go("R7"); go("R7");
        // R8: suspend repeats address 13
        adv_n = 1; go("R8"); go("R8");
        // R5: processor start with write enables low stays a read
        adsp_n = 0; addr = 6'd15; bwe_n = 4'h0; wd = 36'hFFFFFFFFF;
        go("R5");
        adsp_n = 1; bwe_n = 4'hF; go("R5");
        // R6: controller start read with all enables high
        adsc_n = 0; addr = 6'd12; go("R6");
        adsc_n = 1;
        // R3: processor strobe masked by gating select -> suspend at 12
        cg_n = 1; adsp_n = 0; addr = 6'd14; go("R3");
        adv_n = 0; go("R3");            // continue to 13
        cg_n = 0; adsp_n = 1; adv_n = 1;
        // R9: lane writes at 20
        adsc_n = 0; addr = 6'd20; bwe_n = 4'h0; wd = 36'hFFFFFFFFF; go("R9");
        adsc_n = 1; bwe_n = 4'b1010; wd = 36'h0; go("R9");
        bwe_n = 4'hF; go("R9");
        bwe_n = 4'b0111; wd = 36'h123456789; go("R9");
        bwe_n = 4'hF; go("R9");
        // R10: output enable high, then low again
        oe_n = 1; go("R10"); go("R10");
        oe_n = 0; go("R10");
        bwe_n = 4'h0; wd = 36'h555555555; go("R10");  // write cycle
        bwe_n = 4'hF; go("R10");
        // R4: controller strobe with active-high select off
        chi = 0; adsc_n = 0; addr = 6'd12; bwe_n = 4'h0; wd = 36'hDEADBEEF0; go("R4");
        chi = 1; adsc_n = 1; adv_n = 0; go("R11");
        adv_n = 1; go("R11");
        bwe_n = 4'hF; go("R11");
        adsp_n = 0; addr = 6'd12; go("R4");           // 12 unchanged
        // R4: processor strobe with active-low select off
        clo_n = 1; addr = 6'd13; go("R4");
        clo_n = 0; adsp_n = 1; go("R11");
        // R4: gating select off with controller strobe
        cg_n = 1; adsc_n = 0; bwe_n = 4'h0; addr = 6'd20; go("R4");
        cg_n = 0; adsc_n = 1; bwe_n = 4'hF; go("R11");
        adsp_n = 0; addr = 6'd20; go("R4");           // 20 unchanged
        adsp_n = 1; adv_n = 0; go("R7");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule